// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the sixteen configuration and status bits of a serial flash device and decides, on every write-status request, whether the new value may be stored. The protection mode comes from a two-bit field inside the register itself, qualified by the active-low write-protect pin and by the write-enable latch kept elsewhere in the device. One mode locks the register only until the next power cycle. Another mode locks it for good.

Three one-time lock bits can only ever go from 0 to 1. A read-only suspend flag follows the suspend and resume command strobes. The block reports each request with single-cycle pulses one clock later: accepted, rejected by protection, and a request for the write-enable latch to be cleared.

Bit layout of `status` (fields that other logic decodes keep these positions):
- [5:0] range configuration, stored and not decoded here
- [7:6] protect mode: 00 open, 01 pin-qualified, 10 locked until power cycle, 11 locked forever
- [8] and [10] reserved
- [9] quad enable
- [13:11] one-time lock bits 0..2
- [14] complement
- [15] suspend

Top module: `sr_prot_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `status` is 16'h0000 and `wr_ok`, `wr_rej` and `wel_clr` are 0.
- R2: With protect mode 00, a request with `wel`=1 is accepted whatever `wp_n` is. One cycle later, bits [5:0], [7:6], [9] and [14] hold the written data.
- R3: With protect mode 01, a request behaves as in R2 while `wp_n`=1. While `wp_n`=0 it is blocked: `wr_rej` pulses and bits [14:0] keep their value.
- R4: With protect mode 10, every request is blocked and `wr_rej` pulses. A `pwr_cycle` strobe returns the mode to 00 and leaves bits [14:8] and [5:0] unchanged.
- R5: Protect mode 11 blocks every request, and no power cycle or other input ever changes the mode away from 11.
- R6: An accepted write sets each lock bit [13:11] whose data bit is 1. A 0 data bit never clears a lock bit, and no lock bit ever returns to 0 outside reset.
- R7: Bit 15 is set by `susp_cmd` and cleared by `resume_cmd` or `pwr_cycle`. When `susp_cmd` and `resume_cmd` arrive together, the bit clears. Written data never changes bit 15. Bits 8 and 10 always read 0.
- R8: Every request, whether accepted, blocked or dropped, gives a one-cycle `wel_clr` pulse one cycle later.
- R9: `wr_ok` pulses one cycle after an accepted request. `wr_rej` pulses one cycle after a blocked request, whether `wel` is 1 or 0. A request with `wel`=0 under an open mode gives neither pulse. The two pulses never occur together.
- R10: A request in the same cycle as `pwr_cycle` is dropped: the power-cycle effects apply, the write data is not stored, and neither `wr_ok` nor `wr_rej` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write-status request strobe |
| wr_data | input | 16 | Requested new register value |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write-protect pin, active low |
| susp_cmd | input | 1 | Suspend command strobe |
| resume_cmd | input | 1 | Resume command strobe |
| pwr_cycle | input | 1 | Power-down/power-up event strobe |
| status | output | 16 | Current register contents |
| wr_ok | output | 1 | Request accepted pulse |
| wr_rej | output | 1 | Request blocked by protection pulse |
| wel_clr | output | 1 | Clear write-enable latch pulse |

## Verification
The hardest state to reach is the lock-until-power-cycle mode while other fields hold non-zero values. The only way in is an accepted write, so the stimulus first moves through the pin-qualified mode with the pin high, then writes mode 10. It then shows that only a power cycle unlocks the register and that the other fields survive. The stimulus also makes strobes meet in one cycle: suspend with resume, and a write with a power cycle. These cases test the priority rules that ordinary single-strobe traffic never reaches.

// File: rtl/sr_prot_pkg.sv
// Shared field positions and protect-mode type for the status register
// write-protection controller. Assumes a 16-bit register image.
package sr_prot_pkg;

    localparam int SR_W      = 16;
    localparam int CFG_W     = 6;
    localparam int CFG_LSB   = 0;
    localparam int MODE_LSB  = CFG_LSB + CFG_W;   // 6
    localparam int RSV0_BIT  = MODE_LSB + 2;      // 8
    localparam int QE_BIT    = RSV0_BIT + 1;      // 9
    localparam int RSV1_BIT  = QE_BIT + 1;        // 10
    localparam int LOCK_LSB  = RSV1_BIT + 1;      // 11
    localparam int NUM_LOCKS = 3;
    localparam int CMP_BIT   = LOCK_LSB + NUM_LOCKS; // 14
    localparam int SUS_BIT   = CMP_BIT + 1;          // 15

    typedef enum logic [1:0] {
        PM_OPEN     = 2'b00,
        PM_PIN      = 2'b01,
        PM_UNTIL_PC = 2'b10,
        PM_FOREVER  = 2'b11
    } prot_mode_e;

endpackage

// File: rtl/sr_prot_gate.sv
// Protection gate: decides from the current protect mode, the write-protect
// pin and the write-enable latch whether a request is accepted or blocked.
// Assumes a request coinciding with a power-cycle event is dropped.
module sr_prot_gate
    import sr_prot_pkg::*;
(
    input  prot_mode_e mode,
    input  logic       wp_n,
    input  logic       wr_req,
    input  logic       wel,
    input  logic       pwr_cycle,
    output logic       accept,
    output logic       reject
);

    logic blocked;
    logic attempt;

    // Map the protect mode and pin to a blocked/open decision.
    always_comb begin
        unique case (mode)
            PM_OPEN:     blocked = 1'b0;
            PM_PIN:      blocked = !wp_n;
            PM_UNTIL_PC: blocked = 1'b1;
            PM_FOREVER:  blocked = 1'b1;
            default:     blocked = 1'b1;
        endcase
    end

    // Classify the current request.
    always_comb begin
        attempt = wr_req && !pwr_cycle;
        reject  = attempt && blocked;
        accept  = attempt && !blocked && wel;
    end

endmodule

// File: rtl/sr_cfg_store.sv
// Writable configuration fields: range config, protect mode, quad enable and
// complement. Holds them across power cycles, except that the
// lock-until-power-cycle mode falls back to open.
module sr_cfg_store
    import sr_prot_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         pwr_cycle,
    input  logic [W-1:0] cfg_d,
    input  prot_mode_e   mode_d,
    input  logic         qe_d,
    input  logic         cmp_d,
    output logic [W-1:0] cfg_q,
    output prot_mode_e   mode_q,
    output logic         qe_q,
    output logic         cmp_q
);

    // Plain data fields: load on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            qe_q  <= 1'b0;
            cmp_q <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_d;
            qe_q  <= qe_d;
            cmp_q <= cmp_d;
        end
    end

    // Protect mode: the power cycle releases only the temporary lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_OPEN;
        end else if (pwr_cycle) begin
            if (mode_q == PM_UNTIL_PC) begin
                mode_q <= PM_OPEN;
            end
        end else if (load) begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/sr_otp_bank.sv
// One-time lock bits: each bit is set by an accepted write carrying a 1 and
// is never cleared outside reset. Reset models factory-blank state.
module sr_otp_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] set_d,
    output logic [N-1:0] lock_q
);

    for (genvar i = 0; i < N; i++) begin : g_lock
        logic bit_q;

        // Sticky set of lock bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (load && set_d[i]) begin
                bit_q <= 1'b1;
            end
        end

        assign lock_q[i] = bit_q;
    end

endmodule

// File: rtl/sr_susp_flag.sv
// Read-only suspend flag driven by command strobes. A power cycle or a resume
// clears it. Resume outranks a suspend arriving in the same cycle.
module sr_susp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_cmd,
    input  logic resume_cmd,
    input  logic pwr_cycle,
    output logic sus_q
);

    // Suspend flag update with clear-dominant priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sus_q <= 1'b0;
        end else if (pwr_cycle || resume_cmd) begin
            sus_q <= 1'b0;
        end else if (susp_cmd) begin
            sus_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sr_prot_ctrl.sv
// Status register write-protection controller (top). Assembles the register
// image from its field stores, gates write requests through the protection
// rules and reports each request with registered one-cycle pulses.
// Assumes all strobes are synchronous single-cycle pulses.
module sr_prot_ctrl
    import sr_prot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [SR_W-1:0] wr_data,
    input  logic            wel,
    input  logic            wp_n,
    input  logic            susp_cmd,
    input  logic            resume_cmd,
    input  logic            pwr_cycle,
    output logic [SR_W-1:0] status,
    output logic            wr_ok,
    output logic            wr_rej,
    output logic            wel_clr
);

    logic                 accept;
    logic                 reject;
    logic [CFG_W-1:0]     cfg_q;
    prot_mode_e           mode_q;
    logic                 qe_q;
    logic                 cmp_q;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 sus_q;
    logic                 unused_data;

    // Bits of the request that no store takes (read-only or reserved).
    assign unused_data = ^{wr_data[SUS_BIT], wr_data[RSV1_BIT], wr_data[RSV0_BIT]};

    sr_prot_gate gate_i (
        .mode      (mode_q),
        .wp_n      (wp_n),
        .wr_req    (wr_req),
        .wel       (wel),
        .pwr_cycle (pwr_cycle),
        .accept    (accept),
        .reject    (reject)
    );

    sr_cfg_store #(.W(CFG_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .pwr_cycle (pwr_cycle),
        .cfg_d     (wr_data[CFG_LSB +: CFG_W]),
        .mode_d    (prot_mode_e'(wr_data[MODE_LSB +: 2])),
        .qe_d      (wr_data[QE_BIT]),
        .cmp_d     (wr_data[CMP_BIT]),
        .cfg_q     (cfg_q),
        .mode_q    (mode_q),
        .qe_q      (qe_q),
        .cmp_q     (cmp_q)
    );

    sr_otp_bank #(.N(NUM_LOCKS)) otp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .set_d  (wr_data[LOCK_LSB +: NUM_LOCKS]),
        .lock_q (lock_q)
    );

    sr_susp_flag sus_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .susp_cmd   (susp_cmd),
        .resume_cmd (resume_cmd),
        .pwr_cycle  (pwr_cycle),
        .sus_q      (sus_q)
    );

    // Assemble the register image; reserved bits stay 0.
    always_comb begin
        status                          = '0;
        status[CFG_LSB +: CFG_W]        = cfg_q;
        status[MODE_LSB +: 2]           = mode_q;
        status[QE_BIT]                  = qe_q;
        status[LOCK_LSB +: NUM_LOCKS]   = lock_q;
        status[CMP_BIT]                 = cmp_q;
        status[SUS_BIT]                 = sus_q;
    end

    // Register the per-request outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ok   <= 1'b0;
            wr_rej  <= 1'b0;
            wel_clr <= 1'b0;
        end else begin
            wr_ok   <= accept;
            wr_rej  <= reject;
            wel_clr <= wr_req;
        end
    end

endmodule

// File: rtl/sr_prot_chk.sv
// Checker for the write-protection controller, bound to the top module.
// Relates requests, strobes and the visible register image over time.
module sr_prot_chk
    import sr_prot_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_req,
    input logic            wel,
    input logic            wp_n,
    input logic            susp_cmd,
    input logic            resume_cmd,
    input logic            pwr_cycle,
    input logic [SR_W-1:0] status,
    input logic            wr_ok,
    input logic            wr_rej,
    input logic            wel_clr
);

    logic [1:0] mode_v;
    assign mode_v = status[MODE_LSB +: 2];

    // R3
    pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !pwr_cycle && mode_v == 2'b01 && !wp_n)
        |=> (wr_rej && status[SUS_BIT-1:0] == $past(status[SUS_BIT-1:0])));

    // R4
    pc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cycle && mode_v == 2'b10) |=> (status[MODE_LSB +: 2] == 2'b00));

    // R5
    forever_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v == 2'b11) |=> (status[MODE_LSB +: 2] == 2'b11));

    // R6
    otp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status[LOCK_LSB +: NUM_LOCKS] & $past(status[LOCK_LSB +: NUM_LOCKS]))
                  == $past(status[LOCK_LSB +: NUM_LOCKS])));

    // R7
    sus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cycle || resume_cmd) |=> !status[SUS_BIT]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[RSV0_BIT] && !status[RSV1_BIT]);

    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wel_clr);

    // R9
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && wr_rej));

    // R9
    ok_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> $past(wel));

    // R10
    pc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && pwr_cycle) |=> (!wr_ok && !wr_rej));

    // R7 (suspend set when not overridden)
    sus_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_cmd && !resume_cmd && !pwr_cycle) |=> status[SUS_BIT]);

endmodule

bind sr_prot_ctrl sr_prot_chk chk_i (.*);

// File: tb/sr_prot_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks with literal expected values per requirement.
module sr_prot_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        wel = 1'b0;
    logic        wp_n = 1'b1;
    logic        susp_cmd = 1'b0;
    logic        resume_cmd = 1'b0;
    logic        pwr_cycle = 1'b0;
    logic [15:0] status;
    logic        wr_ok;
    logic        wr_rej;
    logic        wel_clr;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    // reference model state
    int       m_mode = 0;
    bit [5:0] m_cfg = 0;
    bit       m_qe = 0, m_cmp = 0, m_sus = 0;
    bit [2:0] m_lock = 0;
    bit       m_ok = 0, m_rej = 0, m_wc = 0;
    bit       started = 0;

    always #10 clk = ~clk;

    sr_prot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .wel(wel), .wp_n(wp_n), .susp_cmd(susp_cmd), .resume_cmd(resume_cmd),
        .pwr_cycle(pwr_cycle), .status(status), .wr_ok(wr_ok),
        .wr_rej(wr_rej), .wel_clr(wel_clr)
    );

    function automatic logic [15:0] model_image();
        logic [15:0] v;
        v        = 16'h0;
        v[5:0]   = m_cfg;
        v[7:6]   = 2'(m_mode);
        v[9]     = m_qe;
        v[13:11] = m_lock;
        v[14]    = m_cmp;
        v[15]    = m_sus;
        return v;
    endfunction

    // reference model update at each rising edge
    always @(posedge clk) begin
        bit blocked;
        if (!rst_n) begin
            m_mode = 0; m_cfg = 0; m_qe = 0; m_cmp = 0; m_sus = 0; m_lock = 0;
            m_ok = 0; m_rej = 0; m_wc = 0;
            started = 1;
        end else begin
            blocked = (m_mode >= 2) || (m_mode == 1 && !wp_n);
            m_ok = 0; m_rej = 0; m_wc = wr_req;
            if (pwr_cycle) begin
                if (m_mode == 2) m_mode = 0;
                m_sus = 0;
            end else begin
                if (wr_req) begin
                    if (blocked) m_rej = 1;
                    else if (wel) begin
                        m_ok = 1;
                        m_cfg = wr_data[5:0];
                        m_mode = int'(wr_data[7:6]);
                        m_qe = wr_data[9];
                        m_cmp = wr_data[14];
                        m_lock = m_lock | wr_data[13:11];
                    end
                end
                if (resume_cmd) m_sus = 0;
                else if (susp_cmd) m_sus = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // model comparison on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(status === model_image(), phase, "status", status, model_image());
            check({wr_ok, wr_rej, wel_clr} === {m_ok, m_rej, m_wc}, phase, "pulses",
                  {13'h0, wr_ok, wr_rej, wel_clr}, {13'h0, m_ok, m_rej, m_wc});
        end
    end

    // one request/strobe cycle, returns at the falling edge where results show
    task automatic step(input bit rq, input logic [15:0] d, input bit we, input bit wp,
                        input bit su, input bit re, input bit pc);
        @(negedge clk);
        wr_req = rq; wr_data = d; wel = we; wp_n = wp;
        susp_cmd = su; resume_cmd = re; pwr_cycle = pc;
        @(negedge clk);
        wr_req = 0; susp_cmd = 0; resume_cmd = 0; pwr_cycle = 0;
    endtask

    task automatic expect_now(input string req, input logic [15:0] st,
                              input bit ok, input bit rej, input bit wc);
        check(status === st, req, "directed status", status, st);
        check({wr_ok, wr_rej, wel_clr} === {ok, rej, wc}, req, "directed pulses",
              {13'h0, wr_ok, wr_rej, wel_clr}, {13'h0, ok, rej, wc});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_now("R1", 16'h0000, 0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        expect_now("R1", 16'h0000, 0, 0, 0);

        phase = "R9";  // wel=0, open mode: neither pulse, latch clear requested
        step(1, 16'h003F, 0, 1, 0, 0, 0);
        expect_now("R9", 16'h0000, 0, 0, 1);

        phase = "R2";  // read-only/reserved data bits set too (R7)
        step(1, 16'hC72A, 1, 0, 0, 0, 0);
        expect_now("R2", 16'h422A, 1, 0, 1);
        expect_now("R7", 16'h422A, 1, 0, 1);

        phase = "R6";
        step(1, 16'h4A2A, 1, 1, 0, 0, 0);
        expect_now("R6", 16'h4A2A, 1, 0, 1);
        step(1, 16'h522A, 1, 1, 0, 0, 0);
        expect_now("R6", 16'h5A2A, 1, 0, 1);
        step(1, 16'h422A, 1, 1, 0, 0, 0);
        expect_now("R6", 16'h5A2A, 1, 0, 1);

        phase = "R3";
        step(1, 16'h5A6A, 1, 1, 0, 0, 0);
        expect_now("R3", 16'h5A6A, 1, 0, 1);
        step(1, 16'h0000, 1, 0, 0, 0, 0);
        expect_now("R3", 16'h5A6A, 0, 1, 1);
        step(1, 16'h0000, 0, 0, 0, 0, 0);       // blocked even with wel=0
        expect_now("R9", 16'h5A6A, 0, 1, 1);
        step(1, 16'h5A6B, 1, 1, 0, 0, 0);
        expect_now("R3", 16'h5A6B, 1, 0, 1);

        phase = "R7";
        step(0, 16'h0, 1, 1, 1, 0, 0);
        expect_now("R7", 16'hDA6B, 0, 0, 0);
        step(0, 16'h0, 1, 1, 1, 1, 0);
        expect_now("R7", 16'h5A6B, 0, 0, 0);
        step(0, 16'h0, 1, 1, 1, 0, 0);
        step(0, 16'h0, 1, 1, 0, 0, 1);
        expect_now("R7", 16'h5A6B, 0, 0, 0);

        phase = "R4";
        step(1, 16'h5AAB, 1, 1, 0, 0, 0);
        expect_now("R4", 16'h5AAB, 1, 0, 1);
        step(1, 16'h0000, 1, 1, 0, 0, 0);
        expect_now("R4", 16'h5AAB, 0, 1, 1);
        step(0, 16'h0, 1, 1, 0, 0, 1);
        expect_now("R4", 16'h5A2B, 0, 0, 0);

        phase = "R10";
        step(1, 16'h0000, 1, 1, 0, 0, 1);
        expect_now("R10", 16'h5A2B, 0, 0, 1);
        expect_now("R8", 16'h5A2B, 0, 0, 1);

        phase = "R5";
        step(1, 16'h5AEB, 1, 0, 0, 0, 0);
        expect_now("R5", 16'h5AEB, 1, 0, 1);
        step(1, 16'h0000, 1, 1, 0, 0, 0);
        expect_now("R5", 16'h5AEB, 0, 1, 1);
        step(0, 16'h0, 1, 1, 0, 0, 1);
        expect_now("R5", 16'h5AEB, 0, 0, 0);
        step(1, 16'h0000, 1, 1, 0, 0, 0);
        expect_now("R5", 16'h5AEB, 0, 1, 1);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule